// File: doc/BRIEF.md
# Trigger Time Estimator

The estimator turns the activity seen during one event window into a single trigger time. A window is opened by a pulse on `win_open` and closed by a pulse on `win_close`. While it is open, two streams feed it. The first is a per-tick summary: the number of track-equivalents present, counted in half units, and a four-bit mask telling which of the four reference segments are present. The second is a stream of individual segment reports, each carrying a fixed-point time and an 8-bit inverse-variance weight.

A two-bit mode latched at window open picks how the time is formed. Three modes pick one sampling tick. The first picks the earliest tick carrying at least 1.5 tracks. The second picks the latest such tick. The third picks the latest tick with all four reference segments present. The fourth mode computes the error-weighted mean of all segment times gathered in the window, using a sequential divider after the window closes. Its precision grows with the number of segments collected. The result leaves as a time in ticks with four fractional bits and a one-cycle valid pulse. A window that yields nothing usable ends with a one-cycle timeout pulse instead.

Top module: `trig_time_est`

## Requirements
- R1: A `win_open` pulse while idle opens a window and latches `mode_sel` (0 = earliest tick with at least 1.5 tracks, 1 = latest tick with at least 1.5 tracks, 2 = latest tick with all four reference segments, 3 = weighted mean). Ticks are numbered from 0 in the order of `tk_vld` inside the window. Tick and segment inputs are ignored outside an open window, and also in the cycle that carries `win_close`.
- R2: In mode 0, `out_time` equals the index of the first tick with `tk_half` >= 3, shifted left by 4 (four fractional bits).
- R3: In mode 1, `out_time` equals the index of the last tick with `tk_half` >= 3, shifted left by 4.
- R4: In mode 2, `out_time` equals the index of the last tick with `tk_full` == 4'b1111, shifted left by 4.
- R5: In mode 3, `out_time` equals floor(sum(w*t) / sum(w)) over the accepted segments, where t is `sg_time` (ticks with four fractional bits) and w is `sg_wt`.
- R6: In mode 3, at most MAX_SEG segments are accepted per window; later ones have no effect on the result.
- R7: In modes 0 to 2, the result appears as a single-cycle pulse registered on the same clock edge that samples `win_close`.
- R8: In mode 3, `busy` is high from the edge that samples `win_close` until the edge that raises `out_vld`, and it falls on that edge. Neither output pulse occurs while `busy` is high. `win_open` and segment inputs are ignored while busy.
- R9: When no tick meets the mode's condition, or in mode 3 when the sum of accepted weights is zero, `out_timeout` pulses for one cycle and `out_vld` stays low. The two pulses never coincide.
- R10: After reset, `out_vld`, `out_timeout` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_open | input | 1 | Opens an event window (pulse) |
| win_close | input | 1 | Closes the event window (pulse) |
| mode_sel | input | 2 | Strategy, latched at window open |
| tk_vld | input | 1 | One sampling tick summary is present |
| tk_half | input | HW | Track-equivalents present in the tick, half units |
| tk_full | input | NSL | Mask of reference segments present in the tick |
| sg_vld | input | 1 | One segment report is present |
| sg_time | input | TW+FRAC | Segment time, ticks with FRAC fractional bits |
| sg_wt | input | WW | Segment inverse-variance weight |
| busy | output | 1 | Division of the weighted mean in progress |
| out_vld | output | 1 | Trigger time valid (pulse) |
| out_timeout | output | 1 | Window produced no result (pulse) |
| out_time | output | TW+FRAC | Trigger time, ticks with FRAC fractional bits |

## Verification
The bench builds the block with TW = 6 and MAX_SEG = 5, so that a window of tens of ticks stays inside the index range. With these values a burst of eight segments runs past the accepted-segment cap, which makes R6 observable. The narrower datapath also shortens the divider, so many weighted windows fit in a run. The sum and quotient arithmetic still covers full 8-bit weights and full-range segment times.

// File: rtl/tte_pkg.sv
package tte_pkg;
  typedef enum logic [1:0] {
    MODE_FIRST_HALF = 2'd0,
    MODE_LAST_HALF  = 2'd1,
    MODE_LAST_FULL  = 2'd2,
    MODE_WEIGHTED   = 2'd3
  } tte_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_OPEN = 2'd1,
    ST_DIV  = 2'd2
  } tte_state_e;
endpackage

// File: rtl/tte_tick_sel.sv
module tte_tick_sel
  import tte_pkg::*;
#(
  parameter int TW       = 10,
  parameter int HW       = 3,
  parameter int HALF_THR = 3,
  parameter int NSL      = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           en,
  input  tte_mode_e      mode,
  input  logic [HW-1:0]  half,
  input  logic [NSL-1:0] full,
  output logic           hit,
  output logic [TW-1:0]  sel_idx
);
  localparam logic [TW-1:0] IDX_MAX = {TW{1'b1}};

  logic [TW-1:0] idx_q, idx_d;
  logic [TW-1:0] sel_q, sel_d;
  logic          hit_q, hit_d;
  logic          cond;

  // condition for this tick depends on the strategy in force
  always_comb begin
    if (mode == MODE_LAST_FULL) cond = &full;
    else                        cond = (half >= HW'(HALF_THR));
  end

  always_comb begin
    idx_d = idx_q;
    sel_d = sel_q;
    hit_d = hit_q;
    if (clr) begin
      idx_d = '0;
      sel_d = '0;
      hit_d = 1'b0;
    end else if (en) begin
      if (cond && ((mode != MODE_FIRST_HALF) || !hit_q)) begin
        sel_d = idx_q;
        hit_d = 1'b1;
      end
      if (idx_q != IDX_MAX) idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      sel_q <= '0;
      hit_q <= 1'b0;
    end else begin
      idx_q <= idx_d;
      sel_q <= sel_d;
      hit_q <= hit_d;
    end
  end

  assign hit     = hit_q;
  assign sel_idx = sel_q;

  AST_FIRST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_q && !clr && mode == MODE_FIRST_HALF) |=> (sel_q == $past(sel_q))); // R2

  AST_LAST_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && mode == MODE_LAST_FULL && (&full)) |=> (hit_q && sel_q == $past(idx_q))); // R4
endmodule

// File: rtl/tte_wacc.sv
module tte_wacc #(
  parameter int TFW     = 14,
  parameter int WW      = 8,
  parameter int MAX_SEG = 32,
  localparam int CW     = $clog2(MAX_SEG + 1),
  localparam int NUMW   = TFW + WW + CW,
  localparam int DENW   = WW + CW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            en,
  input  logic [TFW-1:0]  seg_time,
  input  logic [WW-1:0]   seg_wt,
  output logic [NUMW-1:0] num,
  output logic [DENW-1:0] den
);
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [NUMW-1:0] num_q, num_d;
  logic [DENW-1:0] den_q, den_d;
  logic            take;
  logic [NUMW-1:0] prod;

  assign take = en && (cnt_q < CW'(MAX_SEG));
  assign prod = NUMW'(seg_wt) * NUMW'(seg_time);

  always_comb begin
    cnt_d = cnt_q;
    num_d = num_q;
    den_d = den_q;
    if (clr) begin
      cnt_d = '0;
      num_d = '0;
      den_d = '0;
    end else if (take) begin
      cnt_d = cnt_q + 1'b1;
      num_d = num_q + prod;
      den_d = den_q + DENW'(seg_wt);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      num_q <= '0;
      den_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      num_q <= num_d;
      den_q <= den_d;
    end
  end

  assign num = num_q;
  assign den = den_q;

  AST_SEG_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(MAX_SEG)); // R6

  AST_FULL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CW'(MAX_SEG) && !clr) |=> ($stable(num_q) && $stable(den_q))); // R6
endmodule

// File: rtl/tte_div.sv
module tte_div #(
  parameter int NW    = 24,
  parameter int DW    = 14,
  parameter int QW    = 14,
  localparam int CNTW = $clog2(NW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          busy,
  output logic          done,
  output logic [QW-1:0] quo
);
  logic [NW-1:0]   dvd_q, dvd_d;
  logic [NW-1:0]   quo_q, quo_d;
  logic [DW-1:0]   den_q, den_d;
  logic [DW-1:0]   rem_q, rem_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            busy_q, busy_d;
  logic            done_q, done_d;
  logic [DW:0]     rem_sh;
  logic [DW:0]     rem_sub;
  logic            ge;

  // one restoring step per cycle
  assign rem_sh  = {rem_q, dvd_q[NW-1]};
  assign rem_sub = rem_sh - {1'b0, den_q};
  assign ge      = (rem_sh >= {1'b0, den_q});

  always_comb begin
    dvd_d  = dvd_q;
    quo_d  = quo_q;
    den_d  = den_q;
    rem_d  = rem_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (start) begin
      dvd_d  = num;
      den_d  = den;
      rem_d  = '0;
      quo_d  = '0;
      cnt_d  = CNTW'(NW);
      busy_d = 1'b1;
    end else if (busy_q) begin
      rem_d = ge ? rem_sub[DW-1:0] : rem_sh[DW-1:0];
      dvd_d = dvd_q << 1;
      quo_d = {quo_q[NW-2:0], ge};
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CNTW'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvd_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      dvd_q  <= dvd_d;
      quo_q  <= quo_d;
      den_q  <= den_d;
      rem_q  <= rem_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign quo  = quo_q[QW-1:0];

  AST_QUO_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (quo_q[NW-1:QW] == '0)); // R5

  AST_REM_BELOW_DEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !start) |-> (rem_q < den_q)); // R5

  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(busy_q)); // R8
endmodule

// File: rtl/trig_time_est.sv
module trig_time_est
  import tte_pkg::*;
#(
  parameter int TW       = 10,
  parameter int FRAC     = 4,
  parameter int HW       = 3,
  parameter int HALF_THR = 3,
  parameter int NSL      = 4,
  parameter int WW       = 8,
  parameter int MAX_SEG  = 32,
  localparam int TFW     = TW + FRAC,
  localparam int CW      = $clog2(MAX_SEG + 1),
  localparam int NUMW    = TFW + WW + CW,
  localparam int DENW    = WW + CW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           win_open,
  input  logic           win_close,
  input  logic [1:0]     mode_sel,
  input  logic           tk_vld,
  input  logic [HW-1:0]  tk_half,
  input  logic [NSL-1:0] tk_full,
  input  logic           sg_vld,
  input  logic [TFW-1:0] sg_time,
  input  logic [WW-1:0]  sg_wt,
  output logic           busy,
  output logic           out_vld,
  output logic           out_timeout,
  output logic [TFW-1:0] out_time
);
  tte_state_e      state_q, state_d;
  tte_mode_e       mode_q, mode_d;
  logic            vld_q, vld_d;
  logic            tmo_q, tmo_d;
  logic [TFW-1:0]  time_q, time_d;

  logic            clr;
  logic            in_win;
  logic            tick_en;
  logic            seg_en;
  logic            hit;
  logic [TW-1:0]   sel_idx;
  logic [NUMW-1:0] num;
  logic [DENW-1:0] den;
  logic            div_start;
  logic            div_busy;
  logic            div_done;
  logic [TFW-1:0]  div_quo;

  assign clr     = (state_q == ST_IDLE) && win_open;
  assign in_win  = (state_q == ST_OPEN) && !win_close;
  assign tick_en = in_win && tk_vld;
  assign seg_en  = in_win && sg_vld;

  tte_tick_sel #(
    .TW(TW), .HW(HW), .HALF_THR(HALF_THR), .NSL(NSL)
  ) u_sel (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(tick_en), .mode(mode_q),
    .half(tk_half), .full(tk_full), .hit(hit), .sel_idx(sel_idx)
  );

  tte_wacc #(
    .TFW(TFW), .WW(WW), .MAX_SEG(MAX_SEG)
  ) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(seg_en),
    .seg_time(sg_time), .seg_wt(sg_wt), .num(num), .den(den)
  );

  tte_div #(
    .NW(NUMW), .DW(DENW), .QW(TFW)
  ) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start), .num(num), .den(den),
    .busy(div_busy), .done(div_done), .quo(div_quo)
  );

  always_comb begin
    state_d   = state_q;
    mode_d    = mode_q;
    vld_d     = 1'b0;
    tmo_d     = 1'b0;
    time_d    = time_q;
    div_start = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (win_open) begin
          mode_d  = tte_mode_e'(mode_sel);
          state_d = ST_OPEN;
        end
      end
      ST_OPEN: begin
        if (win_close) begin
          if (mode_q == MODE_WEIGHTED) begin
            if (den == '0) begin
              tmo_d   = 1'b1;
              state_d = ST_IDLE;
            end else begin
              div_start = 1'b1;
              state_d   = ST_DIV;
            end
          end else begin
            vld_d   = hit;
            tmo_d   = !hit;
            time_d  = {sel_idx, {FRAC{1'b0}}};
            state_d = ST_IDLE;
          end
        end
      end
      ST_DIV: begin
        if (div_done) begin
          vld_d   = 1'b1;
          time_d  = div_quo;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_FIRST_HALF;
      vld_q   <= 1'b0;
      tmo_q   <= 1'b0;
      time_q  <= '0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      vld_q   <= vld_d;
      tmo_q   <= tmo_d;
      time_q  <= time_d;
    end
  end

  assign busy        = (state_q == ST_DIV);
  assign out_vld     = vld_q;
  assign out_timeout = tmo_q;
  assign out_time    = time_q;

  AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(vld_q && tmo_q)); // R9

  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!vld_q && !tmo_q)); // R8

  AST_BUSY_ENDS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> vld_q); // R8

  AST_DIV_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DIV) |-> (div_busy || div_done)); // R8

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q || tmo_q) |=> (!vld_q && !tmo_q)); // R7
endmodule

// File: tb/tb_trig_time_est.sv
module tb_trig_time_est;
  localparam int TW      = 6;
  localparam int FRAC    = 4;
  localparam int HW      = 3;
  localparam int NSL     = 4;
  localparam int WW      = 8;
  localparam int MAX_SEG = 5;
  localparam int TFW     = TW + FRAC;

  logic           clk;
  logic           rst_n;
  logic           win_open;
  logic           win_close;
  logic [1:0]     mode_sel;
  logic           tk_vld;
  logic [HW-1:0]  tk_half;
  logic [NSL-1:0] tk_full;
  logic           sg_vld;
  logic [TFW-1:0] sg_time;
  logic [WW-1:0]  sg_wt;
  logic           busy;
  logic           out_vld;
  logic           out_timeout;
  logic [TFW-1:0] out_time;

  int n_chk;
  int n_fail;

  trig_time_est #(
    .TW(TW), .FRAC(FRAC), .HW(HW), .HALF_THR(3), .NSL(NSL), .WW(WW), .MAX_SEG(MAX_SEG)
  ) dut (
    .clk(clk), .rst_n(rst_n), .win_open(win_open), .win_close(win_close),
    .mode_sel(mode_sel), .tk_vld(tk_vld), .tk_half(tk_half), .tk_full(tk_full),
    .sg_vld(sg_vld), .sg_time(sg_time), .sg_wt(sg_wt), .busy(busy),
    .out_vld(out_vld), .out_timeout(out_timeout), .out_time(out_time)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    win_open  = 1'b0;
    win_close = 1'b0;
    tk_vld    = 1'b0;
    tk_half   = '0;
    tk_full   = '0;
    sg_vld    = 1'b0;
    sg_time   = '0;
    sg_wt     = '0;
  endtask

  task automatic open_win(input int m);
    @(negedge clk);
    idle_inputs();
    win_open = 1'b1;
    mode_sel = 2'(m);
    @(negedge clk);
    win_open = 1'b0;
  endtask

  // tick strategies; no_hit keeps every tick below the mode's condition
  task automatic tick_event(input int m, input int n, input bit no_hit, input string req);
    int  idx;
    int  exp_idx;
    bit  exp_hit;
    bit  cond;
    open_win(m);
    idx = 0;
    exp_idx = 0;
    exp_hit = 1'b0;
    for (int i = 0; i < n; i++) begin
      tk_vld = ($urandom_range(0, 3) != 0);
      if (no_hit) begin
        tk_half = HW'($urandom_range(0, 2));
        tk_full = NSL'($urandom_range(0, 14));
      end else begin
        tk_half = HW'($urandom_range(0, 7));
        tk_full = ($urandom_range(0, 2) == 0) ? 4'b1111 : NSL'($urandom_range(0, 15));
      end
      if (tk_vld) begin
        cond = (m == 2) ? (tk_full == 4'b1111) : (tk_half >= 3);
        if (cond && (m != 0 || !exp_hit)) begin
          exp_idx = idx;
          exp_hit = 1'b1;
        end
        idx++;
      end
      @(negedge clk);
    end
    // close cycle carries a qualifying tick that must be ignored (R1)
    tk_vld    = 1'b1;
    tk_half   = 3'd7;
    tk_full   = 4'b1111;
    win_close = 1'b1;
    @(negedge clk);
    idle_inputs();
    // registered on the close edge (R7)
    chk(out_vld == exp_hit, {req, " R7 valid"}, out_vld, exp_hit);
    chk(out_timeout == !exp_hit, {req, " R9 timeout"}, out_timeout, !exp_hit);
    if (exp_hit)
      chk(out_time == TFW'(exp_idx << FRAC), req, out_time, exp_idx << FRAC);
    @(negedge clk);
    chk(!out_vld && !out_timeout, "R7 pulse length", out_vld, 0);
  endtask

  // weighted mean; wmode 0 random, 1 all zero weights, 2 all one segment time
  task automatic wt_event(input int nseg, input int wmode, input string req);
    longint sum_n;
    longint sum_d;
    longint exp_t;
    int     acc;
    int     waited;
    bit     busy_ok;
    int     fixed_t;
    open_win(3);
    sum_n = 0;
    sum_d = 0;
    acc = 0;
    fixed_t = int'($urandom_range(0, 1023));
    for (int i = 0; i < nseg; i++) begin
      sg_vld  = 1'b1;
      sg_time = (wmode == 2) ? TFW'(fixed_t) : TFW'($urandom_range(0, 1023));
      sg_wt   = (wmode == 1) ? 8'd0 : WW'($urandom_range(1, 255));
      if (i == 0 && wmode == 0) sg_wt = 8'd255;
      if (acc < MAX_SEG) begin
        sum_n += longint'(sg_wt) * longint'(sg_time);
        sum_d += longint'(sg_wt);
        acc++;
      end
      @(negedge clk);
    end
    sg_vld    = 1'b1;
    sg_time   = 10'd1023;
    sg_wt     = 8'd255;
    win_close = 1'b1;
    @(negedge clk);
    idle_inputs();
    if (sum_d == 0) begin
      chk(out_timeout == 1'b1, "R9 zero weight timeout", out_timeout, 1);
      chk(out_vld == 1'b0 && busy == 1'b0, "R9 no valid", out_vld, 0);
      return;
    end
    exp_t = sum_n / sum_d;
    waited = 0;
    busy_ok = 1'b1;
    // disturb while busy: a window open and segments must be ignored (R8)
    win_open = 1'b1;
    mode_sel = 2'd0;
    sg_vld   = 1'b1;
    sg_time  = 10'd1000;
    sg_wt    = 8'd200;
    while (!out_vld && !out_timeout && waited < 200) begin
      if (!busy) busy_ok = 1'b0;
      @(negedge clk);
      win_open = 1'b0;
      waited++;
    end
    idle_inputs();
    chk(busy_ok, "R8 busy held", busy_ok, 1);
    chk(busy == 1'b0, "R8 busy falls with result", busy, 0);
    chk(out_vld == 1'b1, "R8 result", out_vld, 1);
    chk(out_time == TFW'(exp_t), req, out_time, exp_t);
    @(negedge clk);
    chk(!out_vld && !busy, "R8 back to idle", out_vld, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    n_chk = 0;
    n_fail = 0;
    mode_sel = 2'd0;
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!out_vld && !out_timeout && !busy, "R10 reset outputs", out_vld, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_vld && !out_timeout && !busy, "R10 after release", busy, 0);

    // inputs while idle must not reach a later window (R1)
    tk_vld = 1'b1; tk_half = 3'd7; tk_full = 4'b1111;
    sg_vld = 1'b1; sg_wt = 8'd50; sg_time = 10'd300;
    repeat (4) @(negedge clk);
    idle_inputs();
    tick_event(0, 10, 1'b1, "R1 idle ticks ignored");
    wt_event(0, 0, "R1 idle segments ignored");

    // directed corners
    tick_event(2, 0, 1'b0, "R4 empty window");
    tick_event(1, 12, 1'b1, "R3 no qualifying tick");
    wt_event(1, 0, "R5 single segment");
    wt_event(4, 2, "R5 equal times");
    wt_event(3, 1, "R9 zero weights");
    wt_event(8, 0, "R6 cap on segments");

    // random windows
    for (int k = 0; k < 12; k++) begin
      tick_event(0, int'($urandom_range(1, 40)), 1'b0, "R2 first half-track tick");
      tick_event(1, int'($urandom_range(1, 40)), 1'b0, "R3 last half-track tick");
      tick_event(2, int'($urandom_range(1, 40)), 1'b0, "R4 last full tick");
      wt_event(int'($urandom_range(1, 8)), 0, "R5 weighted mean");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule